// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-line general-purpose I/O port behind a simple APB-style register bus. Each line can be turned into an output or left as an input. The port drives a per-pin output enable and an output value toward the pads, and it samples the pad inputs through a two-stage synchronizer before software can read them.

Pin data is reached through a window of 256 words. The word address of an access is itself a per-pin mask: byte-address bit n+2 selects pin n. A write through the window updates only the selected pins, so software can set or clear any set of lines in a single store, with no read-modify-write and no lock. A read through the window returns the pin levels at the selected positions and zero elsewhere. A separate direction register sets which lines drive their pads. Every access completes without wait states.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction register and the output data register are 0x00, so `pad_oe` and `pad_out` are both 0x00.
- R2: The direction register sits at byte offset 0x400. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. `pad_oe` equals the register from the clock edge that completes the write, and a read of 0x400 returns it in bits [7:0].
- R3: A write to byte offset 0x000–0x3FC updates output bit n only when address bit n+2 is 1. Every other output bit keeps its value.
- R4: A read from offset 0x000–0x3FC returns the pin level at bit n when address bit n+2 is 1, and 0 at every unselected bit. Data bits [31:8] always read 0.
- R5: A data write to a pin configured as an input leaves that pin's output value unchanged. After the pin is switched to output it drives the value it held before the ignored write, until a new data write reaches it.
- R6: For an output pin the data read returns the value the port drives. For an input pin it returns the synchronized pad level.
- R7: A change on `pad_in` becomes visible to a data read after exactly two rising clock edges. After one edge the read still shows the old level.
- R8: Reads of any offset outside the data window and 0x400 (for example 0x404 and 0x800) return 0. Writes there change neither register.
- R9: `pready` is high in every access phase, so every transfer completes in one access cycle.
- R10: Registers change only in the access phase (`psel` and `penable` both high). A write held in the setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits [1:0] are ignored |
| pwdata | input | 32 | Write data; bits [7:0] are used |
| prdata | output | 32 | Read data, valid while a read is selected |
| pready | output | 1 | Transfer complete; always high |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable toward the pads |
| pad_out | output | 8 | Per-pin output value toward the pads |

## Verification
The bound checker tests these on every cycle: unselected output bits and input-mode bits stay unchanged after a data write, `pad_oe` follows each completed direction write, setup-phase cycles leave both registers untouched, unselected read bits and unmapped reads are zero, and reset clears the pad outputs. Some behaviour is only visible through the bench's directed scenarios. This covers the exact values of masked reads mixing driven and sampled pins, the two-edge input latency, and the retained value that appears when an input pin is switched to output.

// File: rtl/gpio_mask_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the address-masked GPIO port.
// Assumes: nothing beyond IEEE 1800-2017.
package gpio_mask_pkg;

    // Region of the register space selected by one bus address.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_DATA = 2'd1,
        RGN_DIR  = 2'd2
    } gpio_region_e;

endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
// Module: gpio_addr_decode
// Splits a word address into a register region and a per-pin mask.
// The low PIN_COUNT word-address bits are the pin mask inside the
// data window. The direction register is the first word past the window.
// Assumes: the caller drops the byte-lane bits; WORD_W > PIN_COUNT.
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int PIN_COUNT = 8,
    parameter int WORD_W    = 10
) (
    input  logic [WORD_W-1:0]    word_addr,
    output gpio_region_e         region,
    output logic [PIN_COUNT-1:0] pin_mask
);
    localparam int HI_W = WORD_W - PIN_COUNT;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << PIN_COUNT;

    logic [HI_W-1:0] upper_bits;

    assign upper_bits = word_addr[WORD_W-1:PIN_COUNT];
    assign pin_mask   = word_addr[PIN_COUNT-1:0];

    // Classify the address into data window, direction register or nothing.
    always_comb begin
        if (upper_bits == '0)
            region = RGN_DATA;
        else if (word_addr == DIR_WORD)
            region = RGN_DIR;
        else
            region = RGN_NONE;
    end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Module: gpio_in_sync
// Two-flop synchronizer for each pad input line.
// Assumes: pad inputs are asynchronous, one bit per line, no bus coherency.
module gpio_in_sync #(
    parameter int PIN_COUNT = 8,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] async_in,
    output logic [PIN_COUNT-1:0] sync_out
);
    genvar g;
    generate
        for (g = 0; g < PIN_COUNT; g++) begin : g_line
            logic [STAGES-1:0] chain_q;

            // Shift the pad level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q <= '0;
                else
                    chain_q <= {chain_q[STAGES-2:0], async_in[g]};
            end

            assign sync_out[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
// Module: gpio_port_regs
// Holds the direction register and the per-pin output data bits.
// An output bit updates only when its pin is selected by the address
// mask and is currently an output.
// Assumes: write enables are single-cycle access-phase strobes.
module gpio_port_regs #(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dir_we,
    input  logic                 data_we,
    input  logic [PIN_COUNT-1:0] pin_mask,
    input  logic [PIN_COUNT-1:0] wvalue,
    output logic [PIN_COUNT-1:0] dir_q,
    output logic [PIN_COUNT-1:0] out_q
);
    // Direction register: loaded whole on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (dir_we)
            dir_q <= wvalue;
    end

    genvar g;
    generate
        for (g = 0; g < PIN_COUNT; g++) begin : g_pin
            logic bit_q;

            // Output bit: selected, output-mode pins take the written value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (data_we && pin_mask[g] && dir_q[g])
                    bit_q <= wvalue[g];
            end

            assign out_q[g] = bit_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_mask_port.sv
`timescale 1ns/1ps
// Module: gpio_mask_port (top)
// Eight-line GPIO port on an APB-style bus. Data is accessed through an
// address-masked window. Direction is held in one register. Inputs are
// synchronized before they are read. No wait states are inserted.
// Assumes: byte addressing with word-aligned accesses; synchronous
// active-low reset; the pad ring combines pad_oe and pad_out.
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int PIN_COUNT = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    output logic                 pready,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_out
);
    localparam int WORD_W = ADDR_W - 2;

    gpio_region_e         region;
    logic [PIN_COUNT-1:0] pin_mask;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] out_q;
    logic [PIN_COUNT-1:0] sync_in;
    logic [PIN_COUNT-1:0] pin_level;
    logic                 wr_access;
    logic                 rd_select;
    logic                 unused_bus_bits;

    assign unused_bus_bits = ^{paddr[1:0], pwdata[DATA_W-1:PIN_COUNT]};

    gpio_addr_decode #(
        .PIN_COUNT (PIN_COUNT),
        .WORD_W    (WORD_W)
    ) u_decode (
        .word_addr (paddr[ADDR_W-1:2]),
        .region    (region),
        .pin_mask  (pin_mask)
    );

    gpio_in_sync #(
        .PIN_COUNT (PIN_COUNT),
        .STAGES    (2)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_in)
    );

    // Write strobe only in the access phase.
    assign wr_access = psel && penable && pwrite;
    // Read data is presented for the whole selected read transfer.
    assign rd_select = psel && !pwrite;

    gpio_port_regs #(
        .PIN_COUNT (PIN_COUNT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_we  (wr_access && (region == RGN_DIR)),
        .data_we (wr_access && (region == RGN_DATA)),
        .pin_mask(pin_mask),
        .wvalue  (pwdata[PIN_COUNT-1:0]),
        .dir_q   (dir_q),
        .out_q   (out_q)
    );

    // Per-pin level: the driven value for outputs, the sampled pad for inputs.
    assign pin_level = (dir_q & out_q) | (~dir_q & sync_in);

    // Read multiplexer: masked pin levels, direction, or zero.
    always_comb begin
        prdata = '0;
        if (rd_select) begin
            case (region)
                RGN_DATA: prdata[PIN_COUNT-1:0] = pin_level & pin_mask;
                RGN_DIR:  prdata[PIN_COUNT-1:0] = dir_q;
                default:  prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pad_oe  = dir_q;
    assign pad_out = out_q;

endmodule

// File: rtl/gpio_mask_port_checker.sv
`timescale 1ns/1ps
// Module: gpio_mask_port_checker
// Protocol and register-behaviour properties for gpio_mask_port, bound
// to the top module below.
// Assumes: same parameters as the bound instance.
module gpio_mask_port_checker #(
    parameter int PIN_COUNT = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [ADDR_W-3:0]    word_addr,
    input logic [PIN_COUNT-1:0] wbits,
    input logic [DATA_W-1:0]    prdata,
    input logic [PIN_COUNT-1:0] pad_oe,
    input logic [PIN_COUNT-1:0] pad_out
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << PIN_COUNT;

    logic              in_window;
    logic              at_dir;
    logic [DATA_W-1:0] sel_ext;

    assign in_window = (word_addr[WORD_W-1:PIN_COUNT] == '0);
    assign at_dir    = (word_addr == DIR_WORD);
    assign sel_ext   = {{(DATA_W-PIN_COUNT){1'b0}}, word_addr[PIN_COUNT-1:0]};

    // R1: a reset cycle leaves both pad vectors cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0));

    // R2: a completed direction write shows on pad_oe.
    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && at_dir) |=> (pad_oe == $past(wbits)));

    // R3: unselected output bits hold across a data write.
    a_r3_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && in_window)
        |=> (((pad_out ^ $past(pad_out)) & ~$past(word_addr[PIN_COUNT-1:0])) == '0));

    // R4: unselected read bits and the upper data bits are zero.
    a_r4_read_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && in_window) |-> ((prdata & ~sel_ext) == '0));

    // R5: pins in input mode keep their output value across a data write.
    a_r5_input_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && in_window)
        |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0));

    // R8: unmapped reads return zero.
    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && !in_window && !at_dir) |-> (prdata == '0));

    // R8: unmapped writes touch neither register.
    a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && !in_window && !at_dir)
        |=> ($stable(pad_oe) && $stable(pad_out)));

    // R10: a setup-phase cycle changes no register.
    a_r10_setup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind gpio_mask_port gpio_mask_port_checker #(
    .PIN_COUNT (PIN_COUNT),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .word_addr (paddr[ADDR_W-1:2]),
    .wbits     (pwdata[PIN_COUNT-1:0]),
    .prdata    (prdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/gpio_mask_port_test.sv
`timescale 1ns/1ps
// Directed bench for gpio_mask_port: one task per scenario.
module gpio_mask_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_mask_port uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string req, input logic [31:0] actual,
                         input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    // One bus write; the register updates at the edge ending the access phase.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #0.5;
        check("R9 pready on write", {31'd0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // One bus read; data sampled in the access phase.
    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #0.5;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 pad_oe in reset", {24'd0, pad_oe}, 32'h0);
        check("R1 pad_out in reset", {24'd0, pad_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe after reset", {24'd0, pad_oe}, 32'h0);
        check("R1 pad_out after reset", {24'd0, pad_out}, 32'h0);
        bus_read(12'h400, d);
        check("R1 direction readback", d, 32'h0);
    endtask

    task automatic t_direction;
        logic [31:0] d;
        bus_write(12'h400, 32'hFFFF_FFA5);
        check("R2 pad_oe after dir write", {24'd0, pad_oe}, 32'hA5);
        bus_read(12'h400, d);
        check("R2 dir readback", d, 32'hA5);
    endtask

    task automatic t_masked_write;
        bus_write(12'h400, 32'hFF);
        bus_write(12'h3FC, 32'h00);
        check("R3 all-pin clear", {24'd0, pad_out}, 32'h00);
        bus_write(12'h020, 32'hFF);          // pin 3 only
        check("R3 single pin 3", {24'd0, pad_out}, 32'h08);
        bus_write(12'h03C, 32'hA5);          // pins 0..3
        check("R3 low nibble masked", {24'd0, pad_out}, 32'h05);
    endtask

    task automatic t_masked_read;
        logic [31:0] d;
        bus_read(12'h3FC, d);
        check("R4 full mask read", d, 32'h05);
        bus_read(12'h010, d);                // pin 2 only
        check("R4 pin 2 read", d, 32'h04);
        bus_read(12'h3C0, d);                // pins 4..7
        check("R4 upper nibble read", d, 32'h00);
        bus_read(12'h000, d);
        check("R4 empty mask read", d, 32'h00);
    endtask

    task automatic t_input_ignore;
        bus_write(12'h400, 32'h00);
        bus_write(12'h3FC, 32'hFF);
        check("R5 write to inputs ignored", {24'd0, pad_out}, 32'h05);
        bus_write(12'h400, 32'hFF);
        check("R5 old value after switch", {24'd0, pad_out}, 32'h05);
        bus_write(12'h3FC, 32'hFF);
        check("R5 rewrite after switch", {24'd0, pad_out}, 32'hFF);
    endtask

    task automatic t_read_mix;
        logic [31:0] d;
        bus_write(12'h400, 32'h0F);
        pad_in = 8'h3A;
        repeat (3) @(negedge clk);
        bus_read(12'h3FC, d);
        check("R6 mixed output and input read", d, 32'h3F);
        bus_read(12'h0C0, d);                // pins 4,5 (inputs)
        check("R6 input pins read", d, 32'h30);
    endtask

    task automatic t_sync;
        bus_write(12'h400, 32'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h3FC;
        @(negedge clk);
        pad_in = 8'hC3;
        @(posedge clk); #1;
        check("R7 one edge still old", prdata, 32'h00);
        @(posedge clk); #1;
        check("R7 two edges new", prdata, 32'hC3);
        @(negedge clk);
        psel = 1'b0;
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_write(12'h400, 32'h5A);
        bus_write(12'h3FC, 32'hFF);
        bus_write(12'h404, 32'hFF);
        bus_write(12'h800, 32'h00);
        check("R8 pad_oe after unmapped writes", {24'd0, pad_oe}, 32'h5A);
        check("R8 pad_out after unmapped writes", {24'd0, pad_out}, 32'hFF);
        bus_read(12'h404, d);
        check("R8 read 0x404", d, 32'h0);
        bus_read(12'h800, d);
        check("R8 read 0x800", d, 32'h0);
        bus_read(12'h400, d);
        check("R8 dir kept", d, 32'h5A);
    endtask

    task automatic t_setup_only;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h400; pwdata = 32'h00;
        repeat (2) @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check("R10 setup-only dir write", {24'd0, pad_oe}, 32'h5A);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h3FC; pwdata = 32'h00;
        repeat (2) @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check("R10 setup-only data write", {24'd0, pad_out}, 32'hFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        t_direction;
        t_masked_write;
        t_masked_read;
        t_input_ignore;
        t_read_mix;
        t_sync;
        t_unmapped;
        t_setup_only;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule